// File: doc/BRIEF.md
# Endian-Selectable Bus-Width Matcher

This block sits between the narrow external side of a queue port and its 36-bit internal storage. The write path collects successive narrow transfers (18 or 9 bits) into one long word and hands only complete words to storage. The read path takes one long word from storage and returns it as successive narrow transfers. Both paths use valid/ready handshakes on each side. A transfer happens on a rising clock edge where valid and ready are both high.

The input width, the output width and the order of the narrow pieces within a long word are taken from configuration pins while master reset is held. They stay fixed until the next master reset. The same piece order applies to packing and unpacking. Narrow pieces travel on the low bits of the 36-bit external data buses. The unused upper bits of `wr_data` are ignored. The unused upper bits of `rd_data` are driven to zero.

Top module: `bwm_matcher`

## Requirements
- R1: The width codes and the order pin are sampled only while `mrst` is high. Changes on these pins after reset has been released have no effect on packing or unpacking.
- R2: Width code 00 selects 36 bits, 01 selects 18 bits, 10 selects 9 bits and 11 is treated as 36 bits. If the input width is narrow, the output width is forced to 36 bits whatever its code says.
- R3: With `cfg_lsb_first` low at reset (big-endian) and a 9-bit input, the first piece lands in bits [35:27], then [26:18], then [17:9], and the last piece in [8:0].
- R4: With `cfg_lsb_first` high at reset (little-endian) and a 9-bit input, the first piece lands in bits [8:0], then [17:9], then [26:18], and the last piece in [35:27].
- R5: With an 18-bit input, the first half-word lands in [35:18] when big-endian and in [17:0] when little-endian. The second half-word fills the other half.
- R6: With a 9-bit output, a long word is returned as four pieces. Big-endian order is [35:27], [26:18], [17:9], [8:0]. Little-endian order is the reverse. The output bits above bit 8 are zero.
- R7: With an 18-bit output, a long word is returned as two pieces. Big-endian order is [35:18] then [17:0], and little-endian order is the reverse. The output bits above bit 17 are zero.
- R8: With both widths at 36 bits, each word is passed through unchanged. It appears on the storage side the cycle after it is accepted.
- R9: `st_wvalid` stays low until the last narrow piece of a word has been accepted. The assembled word appears the cycle after that piece is accepted.
- R10: While `st_wvalid` is high and `st_wready` is low, the offered word holds its value and `wr_ready` is low.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value. `st_rready` is high only when no word is held, or when the last piece of the held word is being accepted.
- R12: Master reset clears any partially assembled word and both piece counters. After reset, `st_wvalid` and `rd_valid` are low and `wr_ready` and `st_rready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, active high, synchronous; configuration is sampled while high |
| cfg_in_width | input | 2 | Input width code (00=36, 01=18, 10=9, 11=36) |
| cfg_out_width | input | 2 | Output width code, same encoding |
| cfg_lsb_first | input | 1 | 0 = most significant piece first, 1 = least significant piece first |
| wr_valid | input | 1 | Narrow write piece valid |
| wr_ready | output | 1 | Narrow write piece accepted when high |
| wr_data | input | 36 | Write piece, narrow data on the low bits |
| st_wvalid | output | 1 | Complete long word offered to storage |
| st_wready | input | 1 | Storage accepts the long word |
| st_wdata | output | 36 | Long word to storage |
| st_rvalid | input | 1 | Storage offers a long word |
| st_rready | output | 1 | Block takes the long word from storage |
| st_rdata | input | 36 | Long word from storage |
| rd_valid | output | 1 | Narrow read piece valid |
| rd_ready | input | 1 | Consumer accepts the read piece |
| rd_data | output | 36 | Read piece, zero-extended |

## Verification
The assertions assume that the configuration pins matter only while `mrst` is high. They also assume that the storage side and the consumer follow the handshake rules: they neither withdraw nor take data outside a cycle where valid and ready are both high. The stimulus changes configuration pins only around a reset, or deliberately after it to show that they are ignored. Inputs are driven on the falling edge, and a piece is held until the cycle in which it is accepted.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

   typedef enum logic [1:0] {
      BW_FULL = 2'b00,
      BW_HALF = 2'b01,
      BW_LANE = 2'b10
   } bw_mode_e;

   function automatic bw_mode_e bw_decode(input logic [1:0] code);
      case (code)
         2'b01:   return BW_HALF;
         2'b10:   return BW_LANE;
         default: return BW_FULL;
      endcase
   endfunction

endpackage

// File: rtl/bwm_cfg.sv
module bwm_cfg
   import bwm_pkg::*;
(
   input  logic       clk,
   input  logic       mrst,
   input  logic [1:0] in_code,
   input  logic [1:0] out_code,
   input  logic       lsb_pin,
   output bw_mode_e   in_mode,
   output bw_mode_e   out_mode,
   output logic       lsb_first
);

   bw_mode_e in_dec;
   bw_mode_e out_dec;

   always_comb begin
      in_dec  = bw_decode(in_code);
      out_dec = (in_dec != BW_FULL) ? BW_FULL : bw_decode(out_code);
   end

   always_ff @(posedge clk) begin
      if (mrst) begin
         in_mode   <= in_dec;
         out_mode  <= out_dec;
         lsb_first <= lsb_pin;
      end
   end

   // R1
   cfg_hold_chk: assert property (@(posedge clk) disable iff (mrst)
      !mrst |=> ($stable(in_mode) && $stable(out_mode) && $stable(lsb_first)));

   // R2
   both_narrow_chk: assert property (@(posedge clk) disable iff (mrst)
      (in_mode == BW_FULL) || (out_mode == BW_FULL));

endmodule

// File: rtl/bwm_pack.sv
module bwm_pack
   import bwm_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     mrst,
   input  bw_mode_e                 mode,
   input  logic                     lsb_first,
   input  logic                     wr_valid,
   output logic                     wr_ready,
   input  logic [LANE_W*LANES-1:0]  wr_data,
   output logic                     st_wvalid,
   input  logic                     st_wready,
   output logic [LANE_W*LANES-1:0]  st_wdata
);

   localparam int WORD_W     = LANE_W * LANES;
   localparam int HALF_LANES = LANES / 2;
   localparam int CW         = (LANES > 1) ? $clog2(LANES) : 1;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("bwm_pack: LANES must be even and at least 2");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("bwm_pack: LANE_W must be positive");
   end

   logic [CW-1:0]     cnt;
   logic [CW-1:0]     last_idx;
   logic [CW-1:0]     slot;
   logic              hsel;
   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] nxt;
   logic              full;
   logic              accept;
   logic              last;

   always_comb begin
      case (mode)
         BW_HALF: last_idx = CW'(1);
         BW_LANE: last_idx = CW'(LANES - 1);
         default: last_idx = '0;
      endcase
      slot   = lsb_first ? cnt : (CW'(LANES - 1) - cnt);
      hsel   = lsb_first ? cnt[0] : ~cnt[0];
      last   = (cnt == last_idx);
      accept = wr_valid && wr_ready;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic IS_HI = (i >= HALF_LANES);
      logic              en;
      logic [LANE_W-1:0] src;
      always_comb begin
         case (mode)
            BW_HALF: begin
               en  = (hsel == IS_HI);
               src = wr_data[(i % HALF_LANES)*LANE_W +: LANE_W];
            end
            BW_LANE: begin
               en  = (slot == CW'(i));
               src = wr_data[LANE_W-1:0];
            end
            default: begin
               en  = 1'b1;
               src = wr_data[i*LANE_W +: LANE_W];
            end
         endcase
      end
      assign nxt[i*LANE_W +: LANE_W] = en ? src : acc[i*LANE_W +: LANE_W];
   end

   assign wr_ready  = !full || st_wready;
   assign st_wvalid = full;

   always_ff @(posedge clk) begin
      if (mrst) begin
         cnt      <= '0;
         acc      <= '0;
         full     <= 1'b0;
         st_wdata <= '0;
      end else begin
         if (full && st_wready) full <= 1'b0;
         if (accept) begin
            acc <= nxt;
            if (last) begin
               cnt      <= '0;
               st_wdata <= nxt;
               full     <= 1'b1;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   // R10
   wout_hold_chk: assert property (@(posedge clk) disable iff (mrst)
      (st_wvalid && !st_wready) |=> (st_wvalid && $stable(st_wdata)));

   // R10
   wr_block_chk: assert property (@(posedge clk) disable iff (mrst)
      (st_wvalid && !st_wready) |-> !wr_ready);

   // R9
   word_src_chk: assert property (@(posedge clk) disable iff (mrst)
      $rose(st_wvalid) |-> $past(wr_valid && wr_ready));

   // R9
   cnt_range_chk: assert property (@(posedge clk) disable iff (mrst)
      cnt <= last_idx);

endmodule

// File: rtl/bwm_unpack.sv
module bwm_unpack
   import bwm_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     mrst,
   input  bw_mode_e                 mode,
   input  logic                     lsb_first,
   input  logic                     st_rvalid,
   output logic                     st_rready,
   input  logic [LANE_W*LANES-1:0]  st_rdata,
   output logic                     rd_valid,
   input  logic                     rd_ready,
   output logic [LANE_W*LANES-1:0]  rd_data
);

   localparam int WORD_W = LANE_W * LANES;
   localparam int HALF_W = WORD_W / 2;
   localparam int CW     = (LANES > 1) ? $clog2(LANES) : 1;

   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("bwm_unpack: LANES must be even and at least 2");
   end

   logic [CW-1:0]     cnt;
   logic [CW-1:0]     last_idx;
   logic [CW-1:0]     slot;
   logic              hsel;
   logic [WORD_W-1:0] hold;
   logic              held;
   logic              take;
   logic              last;

   always_comb begin
      case (mode)
         BW_HALF: last_idx = CW'(1);
         BW_LANE: last_idx = CW'(LANES - 1);
         default: last_idx = '0;
      endcase
      slot = lsb_first ? cnt : (CW'(LANES - 1) - cnt);
      hsel = lsb_first ? cnt[0] : ~cnt[0];
      last = (cnt == last_idx);
      take = held && rd_ready;
   end

   always_comb begin
      rd_data = '0;
      case (mode)
         BW_HALF: rd_data[HALF_W-1:0] = hsel ? hold[HALF_W +: HALF_W] : hold[HALF_W-1:0];
         BW_LANE: rd_data[LANE_W-1:0] = hold[int'(slot)*LANE_W +: LANE_W];
         default: rd_data = hold;
      endcase
   end

   assign rd_valid  = held;
   assign st_rready = !held || (rd_ready && last);

   always_ff @(posedge clk) begin
      if (mrst) begin
         cnt  <= '0;
         hold <= '0;
         held <= 1'b0;
      end else begin
         if (take) begin
            if (last) begin
               cnt  <= '0;
               held <= 1'b0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
         if (st_rvalid && st_rready) begin
            hold <= st_rdata;
            held <= 1'b1;
         end
      end
   end

   // R11
   rout_hold_chk: assert property (@(posedge clk) disable iff (mrst)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   // R11
   fetch_chk: assert property (@(posedge clk) disable iff (mrst)
      (st_rvalid && st_rready) |=> rd_valid);

   // R11
   no_early_fetch_chk: assert property (@(posedge clk) disable iff (mrst)
      (rd_valid && !rd_ready) |-> !st_rready);

endmodule

// File: rtl/bwm_matcher.sv
module bwm_matcher
   import bwm_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     mrst,
   input  logic [1:0]               cfg_in_width,
   input  logic [1:0]               cfg_out_width,
   input  logic                     cfg_lsb_first,
   input  logic                     wr_valid,
   output logic                     wr_ready,
   input  logic [LANE_W*LANES-1:0]  wr_data,
   output logic                     st_wvalid,
   input  logic                     st_wready,
   output logic [LANE_W*LANES-1:0]  st_wdata,
   input  logic                     st_rvalid,
   output logic                     st_rready,
   input  logic [LANE_W*LANES-1:0]  st_rdata,
   output logic                     rd_valid,
   input  logic                     rd_ready,
   output logic [LANE_W*LANES-1:0]  rd_data
);

   bw_mode_e in_mode;
   bw_mode_e out_mode;
   logic     lsb_first;

   bwm_cfg i_cfg (
      .clk       (clk),
      .mrst      (mrst),
      .in_code   (cfg_in_width),
      .out_code  (cfg_out_width),
      .lsb_pin   (cfg_lsb_first),
      .in_mode   (in_mode),
      .out_mode  (out_mode),
      .lsb_first (lsb_first)
   );

   bwm_pack #(.LANE_W(LANE_W), .LANES(LANES)) i_pack (
      .clk       (clk),
      .mrst      (mrst),
      .mode      (in_mode),
      .lsb_first (lsb_first),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .wr_data   (wr_data),
      .st_wvalid (st_wvalid),
      .st_wready (st_wready),
      .st_wdata  (st_wdata)
   );

   bwm_unpack #(.LANE_W(LANE_W), .LANES(LANES)) i_unpack (
      .clk       (clk),
      .mrst      (mrst),
      .mode      (out_mode),
      .lsb_first (lsb_first),
      .st_rvalid (st_rvalid),
      .st_rready (st_rready),
      .st_rdata  (st_rdata),
      .rd_valid  (rd_valid),
      .rd_ready  (rd_ready),
      .rd_data   (rd_data)
   );

   // R12
   reset_idle_chk: assert property (@(posedge clk)
      $fell(mrst) |-> (!st_wvalid && !rd_valid && wr_ready && st_rready));

endmodule

// File: tb/test_bwm_matcher.sv
module test_bwm_matcher;

   logic        clk = 1'b0;
   logic        mrst = 1'b1;
   logic [1:0]  cfg_in_width = 2'b00;
   logic [1:0]  cfg_out_width = 2'b00;
   logic        cfg_lsb_first = 1'b0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [35:0] wr_data = '0;
   logic        st_wvalid;
   logic        st_wready = 1'b1;
   logic [35:0] st_wdata;
   logic        st_rvalid = 1'b0;
   logic        st_rready;
   logic [35:0] st_rdata = '0;
   logic        rd_valid;
   logic        rd_ready = 1'b1;
   logic [35:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   bwm_matcher i_bwm_matcher (
      .clk(clk), .mrst(mrst),
      .cfg_in_width(cfg_in_width), .cfg_out_width(cfg_out_width),
      .cfg_lsb_first(cfg_lsb_first),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .st_wvalid(st_wvalid), .st_wready(st_wready), .st_wdata(st_wdata),
      .st_rvalid(st_rvalid), .st_rready(st_rready), .st_rdata(st_rdata),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] iw, input logic [1:0] ow, input logic lsb);
      @(negedge clk);
      mrst = 1'b1; cfg_in_width = iw; cfg_out_width = ow; cfg_lsb_first = lsb;
      wr_valid = 1'b0; st_rvalid = 1'b0; st_wready = 1'b1; rd_ready = 1'b1;
      repeat (2) @(negedge clk);
      mrst = 1'b0;
   endtask

   task automatic push(input logic [35:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_data = d;
      #1;
      while (!wr_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic feed(input logic [35:0] w);
      @(negedge clk);
      st_rvalid = 1'b1; st_rdata = w;
      #1;
      while (!st_rready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      st_rvalid = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset(2'b10, 2'b00, 1'b0);
      chk("R12 st_wvalid idle", {35'd0, st_wvalid}, 36'd0);
      chk("R12 rd_valid idle", {35'd0, rd_valid}, 36'd0);
      chk("R12 wr_ready idle", {35'd0, wr_ready}, 36'd1);
      chk("R12 st_rready idle", {35'd0, st_rready}, 36'd1);
   endtask

   task automatic t_pack9(input logic lsb);
      logic [8:0] p [4];
      logic [35:0] exp;
      p[0] = 9'h1A3; p[1] = 9'h05C; p[2] = 9'h0F0; p[3] = 9'h12D;
      do_reset(2'b10, 2'b00, lsb);
      for (int k = 0; k < 3; k++) begin
         push({27'd0, p[k]});
         chk("R9 no partial word", {35'd0, st_wvalid}, 36'd0);
      end
      push({27'd0, p[3]});
      exp = lsb ? {p[3], p[2], p[1], p[0]} : {p[0], p[1], p[2], p[3]};
      chk("R9 word offered", {35'd0, st_wvalid}, 36'd1);
      if (lsb) chk("R4 pack 9 little-endian", st_wdata, exp);
      else     chk("R3 pack 9 big-endian", st_wdata, exp);
   endtask

   task automatic t_pack18(input logic lsb);
      logic [17:0] a, b;
      a = 18'h2B1C7; b = 18'h0D35E;
      do_reset(2'b01, 2'b00, lsb);
      push({18'h3FFFF, a});
      chk("R5 half not visible", {35'd0, st_wvalid}, 36'd0);
      push({18'h3FFFF, b});
      chk("R5 pack 18", st_wdata, lsb ? {b, a} : {a, b});
   endtask

   task automatic t_unpack9(input logic lsb);
      logic [35:0] w;
      logic [8:0]  e;
      w = 36'hA5C3_9E1B4;
      do_reset(2'b00, 2'b10, lsb);
      feed(w);
      for (int k = 0; k < 4; k++) begin
         e = lsb ? w[k*9 +: 9] : w[(3-k)*9 +: 9];
         chk("R6 unpack 9 valid", {35'd0, rd_valid}, 36'd1);
         chk("R6 unpack 9 piece", rd_data, {27'd0, e});
         @(negedge clk);
      end
      chk("R6 unpack 9 drained", {35'd0, rd_valid}, 36'd0);
   endtask

   task automatic t_unpack18(input logic lsb);
      logic [35:0] w;
      w = 36'h3_7F01_C2D8;
      do_reset(2'b00, 2'b01, lsb);
      feed(w);
      chk("R7 unpack 18 first", rd_data, {18'd0, lsb ? w[17:0] : w[35:18]});
      @(negedge clk);
      chk("R7 unpack 18 second", rd_data, {18'd0, lsb ? w[35:18] : w[17:0]});
      @(negedge clk);
      chk("R7 unpack 18 drained", {35'd0, rd_valid}, 36'd0);
   endtask

   task automatic t_passthru();
      do_reset(2'b00, 2'b00, 1'b0);
      push(36'h9_8765_4321);
      chk("R8 pass write valid", {35'd0, st_wvalid}, 36'd1);
      chk("R8 pass write data", st_wdata, 36'h9_8765_4321);
      feed(36'h1_2345_6789);
      chk("R8 pass read data", rd_data, 36'h1_2345_6789);
   endtask

   task automatic t_codes();
      do_reset(2'b11, 2'b11, 1'b1);
      push(36'hF_0F0F_0F0F);
      chk("R2 code 11 is full width", st_wdata, 36'hF_0F0F_0F0F);
      do_reset(2'b01, 2'b10, 1'b0);
      feed(36'hC_AFE0_1234);
      chk("R2 narrow input forces full output", rd_data, 36'hC_AFE0_1234);
      @(negedge clk);
      chk("R2 single read per word", {35'd0, rd_valid}, 36'd0);
   endtask

   task automatic t_cfg_frozen();
      do_reset(2'b10, 2'b00, 1'b0);
      @(negedge clk);
      cfg_in_width = 2'b00; cfg_out_width = 2'b01; cfg_lsb_first = 1'b1;
      push(36'h0_0000_0001);
      chk("R1 pins ignored after reset", {35'd0, st_wvalid}, 36'd0);
      push(36'h0_0000_0002);
      push(36'h0_0000_0003);
      push(36'h0_0000_0004);
      chk("R1 still big-endian 9", st_wdata, {9'd1, 9'd2, 9'd3, 9'd4});
      feed(36'h5_5555_5555);
      chk("R1 output width unchanged", rd_data, 36'h5_5555_5555);
   endtask

   task automatic t_wback();
      do_reset(2'b00, 2'b00, 1'b0);
      st_wready = 1'b0;
      push(36'h7_1111_2222);
      chk("R10 offered", {35'd0, st_wvalid}, 36'd1);
      chk("R10 wr_ready low", {35'd0, wr_ready}, 36'd0);
      @(negedge clk);
      chk("R10 data held", st_wdata, 36'h7_1111_2222);
      chk("R10 still offered", {35'd0, st_wvalid}, 36'd1);
      st_wready = 1'b1;
      #1;
      chk("R10 ready follows storage", {35'd0, wr_ready}, 36'd1);
      @(negedge clk);
      chk("R10 released", {35'd0, st_wvalid}, 36'd0);
   endtask

   task automatic t_rback();
      logic [35:0] w;
      w = 36'h8_4433_2211;
      do_reset(2'b00, 2'b10, 1'b0);
      rd_ready = 1'b0;
      feed(w);
      @(negedge clk);
      chk("R11 piece held", rd_data, {27'd0, w[35:27]});
      chk("R11 no fetch while held", {35'd0, st_rready}, 36'd0);
      rd_ready = 1'b1;
      #1;
      chk("R11 no fetch before last", {35'd0, st_rready}, 36'd0);
      repeat (3) @(negedge clk);
      chk("R11 last piece", rd_data, {27'd0, w[8:0]});
      chk("R11 fetch on last", {35'd0, st_rready}, 36'd1);
   endtask

   task automatic t_reset_partial();
      do_reset(2'b10, 2'b00, 1'b1);
      push(36'h0_0000_01FF);
      push(36'h0_0000_01FF);
      do_reset(2'b10, 2'b00, 1'b1);
      chk("R12 partial word dropped", {35'd0, st_wvalid}, 36'd0);
      push(36'h0_0000_0011);
      push(36'h0_0000_0022);
      push(36'h0_0000_0033);
      push(36'h0_0000_0044);
      chk("R12 fresh word", st_wdata, {9'h044, 9'h033, 9'h022, 9'h011});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset_state();
      t_pack9(1'b0);
      t_pack9(1'b1);
      t_pack18(1'b0);
      t_pack18(1'b1);
      t_unpack9(1'b0);
      t_unpack9(1'b1);
      t_unpack18(1'b0);
      t_unpack18(1'b1);
      t_passthru();
      t_codes();
      t_cfg_frozen();
      t_wback();
      t_rback();
      t_reset_partial();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule